// File: doc/BRIEF.md
# Two-Way Mailbox Register Pair

This block sits beside a dual-clock FIFO and gives its two ports a side channel for single words. Port A can leave one word for port B in the first mailbox register, and port B can leave one word for port A in the second. Each port has a mailbox select input. When that select is high, an access on the port goes to the mailbox instead of the FIFO, and the FIFO's advance strobe for that port stays low.

Each mailbox has a vacancy flag in the writer's clock domain. The flag falls on the writer's clock edge that stores a word. It rises again once the other port has read the word. The writer posts the word as a toggle, and the toggle crosses into the reader's domain through a two-flop synchronizer. A read only acknowledges a word that has arrived in the reader's domain. The acknowledgement returns through another two-flop synchronizer. Reading a mailbox does not destroy its contents.

Top module: `mbx_pair`

## Requirements
- R1: After reset both vacancy flags are 1 (vacant) and both mailbox registers hold zero.
- R2: An access on port A with csN=0, en=1, write=1 and mbx=1 at a rising clkA edge stores aDin into mailbox 1, provided mail1Vacant is 1. From that edge on, mail1Vacant is 0.
- R3: An access on port B with csN=0, en=1, write=1 and mbx=1 at a rising clkB edge stores bDin into mailbox 2, provided mail2Vacant is 1. From that edge on, mail2Vacant is 0.
- R4: When csN=0 and write=0 on a port, its drive output is 1. Port B then outputs mailbox 1 if bMbx=1, or bFifoQ if bMbx=0. Port A outputs mailbox 2 or aFifoQ in the same way.
- R5: Reading a mailbox leaves its word in place, so a second read returns the same word.
- R6: A read at the other port (csN=0, en=1, write=0, mbx=1) of a word that has reached that port's domain brings the writer's vacancy flag back to 1 within 8 writer clock cycles.
- R7: A write to a mailbox whose vacancy flag is 0 is ignored, and the stored word is unchanged.
- R8: A port's FIFO advance output is 1 for a selected, enabled access with mbx=0. It is 0 whenever mbx=1.
- R9: A read made while the mailbox is vacant, or before a new word has crossed into the reader's domain, does not set the vacancy flag. After such a read, a following write keeps the flag at 0 until a real read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkA | input | 1 | Port A clock |
| clkB | input | 1 | Port B clock |
| rstN | input | 1 | Asynchronous reset, active low |
| aCsN | input | 1 | Port A select, active low |
| aEn | input | 1 | Port A enable |
| aWrite | input | 1 | Port A direction, 1 = write |
| aMbx | input | 1 | Port A mailbox select |
| aDin | input | 36 | Port A write data |
| aFifoQ | input | 36 | FIFO output word toward port A |
| aDout | output | 36 | Port A read data |
| aDrive | output | 1 | Port A output drive enable |
| aFifoAdv | output | 1 | Port A FIFO advance strobe |
| mail1Vacant | output | 1 | Mailbox 1 vacancy flag (clkA domain) |
| bCsN | input | 1 | Port B select, active low |
| bEn | input | 1 | Port B enable |
| bWrite | input | 1 | Port B direction, 1 = write |
| bMbx | input | 1 | Port B mailbox select |
| bDin | input | 36 | Port B write data |
| bFifoQ | input | 36 | FIFO output word toward port B |
| bDout | output | 36 | Port B read data |
| bDrive | output | 1 | Port B output drive enable |
| bFifoAdv | output | 1 | Port B FIFO advance strobe |
| mail2Vacant | output | 1 | Mailbox 2 vacancy flag (clkB domain) |

## Verification
Words with all zeros, all ones, alternating bits and mixed values go through both mailboxes. This separates a stuck bit or a crossed mux leg from correct storage. FIFO reads are mixed with mailbox reads to show that the output mux and the advance strobe follow the select. Writes into a full mailbox, repeated reads, and a read made while the mailbox is vacant show that no word is overwritten or lost. They also show that a stale acknowledgement cannot free the flag early. Both mailboxes are also written in the same window to show the two directions are independent.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic loadMail1;  // capture aDin into mailbox 1 (clkA)
    logic loadMail2;  // capture bDin into mailbox 2 (clkB)
    logic showMail1;  // port B output shows mailbox 1
    logic showMail2;  // port A output shows mailbox 2
  } mbx_strobe_t;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_handshake.sv
module mbx_handshake #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clkWr,
  input  logic clkRd,
  input  logic rstN,
  input  logic wrReq,
  input  logic rdReq,
  output logic accept,
  output logic vacant
);
  logic postTgl;    // writer side, flips per accepted word
  logic postAtRd;   // post toggle seen by reader
  logic ackTgl;     // reader side, copies post toggle on read
  logic ackAtWr;    // acknowledgement seen by writer

  assign vacant = (postTgl == ackAtWr);
  assign accept = wrReq && vacant;

  always_ff @(posedge clkWr or negedge rstN) begin
    if (!rstN)       postTgl <= 1'b0;
    else if (accept) postTgl <= ~postTgl;
  end

  mbx_sync #(.STAGES(SYNC_STAGES)) u_fwd (
    .clk(clkRd), .rstN(rstN), .d(postTgl), .q(postAtRd)
  );

  // A read only acknowledges the post that has already arrived
  always_ff @(posedge clkRd or negedge rstN) begin
    if (!rstN)      ackTgl <= 1'b0;
    else if (rdReq) ackTgl <= postAtRd;
  end

  mbx_sync #(.STAGES(SYNC_STAGES)) u_back (
    .clk(clkWr), .rstN(rstN), .d(ackTgl), .q(ackAtWr)
  );
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clkA,
  input  logic        clkB,
  input  logic        rstN,
  input  logic        aCsN,
  input  logic        aEn,
  input  logic        aWrite,
  input  logic        aMbx,
  input  logic        bCsN,
  input  logic        bEn,
  input  logic        bWrite,
  input  logic        bMbx,
  output mbx_strobe_t strobe,
  output logic        aDrive,
  output logic        bDrive,
  output logic        aFifoAdv,
  output logic        bFifoAdv,
  output logic        mail1Vacant,
  output logic        mail2Vacant
);
  logic aActive, bActive;
  logic aMailWr, aMailRd, bMailWr, bMailRd;
  logic m1Accept, m2Accept;

  assign aActive = !aCsN && aEn;
  assign bActive = !bCsN && bEn;

  assign aMailWr = aActive && aWrite && aMbx;
  assign aMailRd = aActive && !aWrite && aMbx;
  assign bMailWr = bActive && bWrite && bMbx;
  assign bMailRd = bActive && !bWrite && bMbx;

  assign aFifoAdv = aActive && !aMbx;
  assign bFifoAdv = bActive && !bMbx;
  assign aDrive   = !aCsN && !aWrite;
  assign bDrive   = !bCsN && !bWrite;

  // Mailbox 1: written on clkA, read on clkB
  mbx_handshake #(.SYNC_STAGES(SYNC_STAGES)) u_m1 (
    .clkWr(clkA), .clkRd(clkB), .rstN(rstN),
    .wrReq(aMailWr), .rdReq(bMailRd),
    .accept(m1Accept), .vacant(mail1Vacant)
  );

  // Mailbox 2: written on clkB, read on clkA
  mbx_handshake #(.SYNC_STAGES(SYNC_STAGES)) u_m2 (
    .clkWr(clkB), .clkRd(clkA), .rstN(rstN),
    .wrReq(bMailWr), .rdReq(aMailRd),
    .accept(m2Accept), .vacant(mail2Vacant)
  );

  always_comb begin
    strobe.loadMail1 = m1Accept;
    strobe.loadMail2 = m2Accept;
    strobe.showMail1 = bMbx;
    strobe.showMail2 = aMbx;
  end
endmodule

// File: rtl/mbx_datapath.sv
module mbx_datapath
  import mbx_pkg::*;
#(
  parameter int WIDTH = 36
) (
  input  logic             clkA,
  input  logic             clkB,
  input  logic             rstN,
  input  mbx_strobe_t      strobe,
  input  logic [WIDTH-1:0] aDin,
  input  logic [WIDTH-1:0] bDin,
  input  logic [WIDTH-1:0] aFifoQ,
  input  logic [WIDTH-1:0] bFifoQ,
  output logic [WIDTH-1:0] aDout,
  output logic [WIDTH-1:0] bDout
);
  logic [WIDTH-1:0] mail1Q, mail2Q;

  always_ff @(posedge clkA or negedge rstN) begin
    if (!rstN)                 mail1Q <= '0;
    else if (strobe.loadMail1) mail1Q <= aDin;
  end

  always_ff @(posedge clkB or negedge rstN) begin
    if (!rstN)                 mail2Q <= '0;
    else if (strobe.loadMail2) mail2Q <= bDin;
  end

  assign bDout = strobe.showMail1 ? mail1Q : bFifoQ;
  assign aDout = strobe.showMail2 ? mail2Q : aFifoQ;
endmodule

// File: rtl/mbx_pair.sv
module mbx_pair
  import mbx_pkg::*;
#(
  parameter int WIDTH       = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clkA,
  input  logic             clkB,
  input  logic             rstN,
  input  logic             aCsN,
  input  logic             aEn,
  input  logic             aWrite,
  input  logic             aMbx,
  input  logic [WIDTH-1:0] aDin,
  input  logic [WIDTH-1:0] aFifoQ,
  output logic [WIDTH-1:0] aDout,
  output logic             aDrive,
  output logic             aFifoAdv,
  output logic             mail1Vacant,
  input  logic             bCsN,
  input  logic             bEn,
  input  logic             bWrite,
  input  logic             bMbx,
  input  logic [WIDTH-1:0] bDin,
  input  logic [WIDTH-1:0] bFifoQ,
  output logic [WIDTH-1:0] bDout,
  output logic             bDrive,
  output logic             bFifoAdv,
  output logic             mail2Vacant
);
  mbx_strobe_t strobe;

  mbx_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clkA(clkA), .clkB(clkB), .rstN(rstN),
    .aCsN(aCsN), .aEn(aEn), .aWrite(aWrite), .aMbx(aMbx),
    .bCsN(bCsN), .bEn(bEn), .bWrite(bWrite), .bMbx(bMbx),
    .strobe(strobe),
    .aDrive(aDrive), .bDrive(bDrive),
    .aFifoAdv(aFifoAdv), .bFifoAdv(bFifoAdv),
    .mail1Vacant(mail1Vacant), .mail2Vacant(mail2Vacant)
  );

  mbx_datapath #(.WIDTH(WIDTH)) u_dp (
    .clkA(clkA), .clkB(clkB), .rstN(rstN),
    .strobe(strobe),
    .aDin(aDin), .bDin(bDin),
    .aFifoQ(aFifoQ), .bFifoQ(bFifoQ),
    .aDout(aDout), .bDout(bDout)
  );
endmodule

// File: rtl/mbx_pair_chk.sv
module mbx_pair_chk #(
  parameter int WIDTH = 36
) (
  input logic             clkA,
  input logic             clkB,
  input logic             rstN,
  input logic             aCsN,
  input logic             aEn,
  input logic             aWrite,
  input logic             aMbx,
  input logic [WIDTH-1:0] aFifoQ,
  input logic [WIDTH-1:0] aDout,
  input logic             aDrive,
  input logic             aFifoAdv,
  input logic             mail1Vacant,
  input logic             bCsN,
  input logic             bEn,
  input logic             bWrite,
  input logic             bMbx,
  input logic [WIDTH-1:0] bFifoQ,
  input logic [WIDTH-1:0] bDout,
  input logic             bDrive,
  input logic             bFifoAdv,
  input logic             mail2Vacant
);
  p_reset_vacant_r1: assert property (@(posedge clkA)
    !rstN |-> (mail1Vacant && mail2Vacant));

  p_fill_mail1_r2: assert property (@(posedge clkA) disable iff (!rstN)
    (!aCsN && aEn && aWrite && aMbx && mail1Vacant) |=> !mail1Vacant);

  p_fill_mail2_r3: assert property (@(posedge clkB) disable iff (!rstN)
    (!bCsN && bEn && bWrite && bMbx && mail2Vacant) |=> !mail2Vacant);

  p_fifo_path_b_r4: assert property (@(posedge clkB) disable iff (!rstN)
    (!bCsN && !bWrite && !bMbx) |-> (bDrive && bDout == bFifoQ));

  p_fifo_path_a_r4: assert property (@(posedge clkA) disable iff (!rstN)
    (!aCsN && !aWrite && !aMbx) |-> (aDrive && aDout == aFifoQ));

  p_hold_fifo_a_r8: assert property (@(posedge clkA) disable iff (!rstN)
    aMbx |-> !aFifoAdv);

  p_hold_fifo_b_r8: assert property (@(posedge clkB) disable iff (!rstN)
    bMbx |-> !bFifoAdv);

  // R9: the flag only falls on an accepted write
  p_fall_on_write_r9: assert property (@(posedge clkA) disable iff (!rstN)
    $fell(mail1Vacant) |-> $past(!aCsN && aEn && aWrite && aMbx));

  p_fall_on_write_b_r9: assert property (@(posedge clkB) disable iff (!rstN)
    $fell(mail2Vacant) |-> $past(!bCsN && bEn && bWrite && bMbx));
endmodule

bind mbx_pair mbx_pair_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_mbx_pair.sv
module sim_mbx_pair;
  localparam int W = 36;
  localparam logic [W-1:0] A_FIFO = 36'hA_5A5A_5A5A;
  localparam logic [W-1:0] B_FIFO = 36'h3_C3C3_C3C3;

  logic clkA = 1'b0, clkB = 1'b0, rstN = 1'b0;
  logic aCsN = 1'b1, aEn = 1'b0, aWrite = 1'b0, aMbx = 1'b0;
  logic bCsN = 1'b1, bEn = 1'b0, bWrite = 1'b0, bMbx = 1'b0;
  logic [W-1:0] aDin = '0, bDin = '0;
  logic [W-1:0] aFifoQ = A_FIFO, bFifoQ = B_FIFO;
  logic [W-1:0] aDout, bDout;
  logic aDrive, bDrive, aFifoAdv, bFifoAdv, mail1Vacant, mail2Vacant;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 0;
  string tagB = "R4";
  string tagA = "R4";

  // Scoreboard: last entry is the word each mailbox must hold
  logic [W-1:0] exp1Q[$];
  logic [W-1:0] exp2Q[$];

  always #2.5 clkA = ~clkA;   // 200 MHz
  always #3.5 clkB = ~clkB;

  mbx_pair u0 (.*);

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitors compare read data at the edge that performs the read
  always @(posedge clkB) begin
    if (rstN && !bCsN && bEn && !bWrite)
      check(tagB, bDout, bMbx ? exp1Q[$] : B_FIFO);
  end

  always @(posedge clkA) begin
    if (rstN && !aCsN && aEn && !aWrite)
      check(tagA, aDout, aMbx ? exp2Q[$] : A_FIFO);
  end

  task automatic portAWrite(logic mbx, logic [W-1:0] data);
    @(negedge clkA);
    aCsN = 0; aEn = 1; aWrite = 1; aMbx = mbx; aDin = data;
    if (mbx && mail1Vacant) exp1Q.push_back(data);
    #1 check("R8 port A advance", {35'b0, aFifoAdv}, {35'b0, !mbx});
    @(negedge clkA);
    aCsN = 1; aEn = 0; aWrite = 0; aMbx = 0;
  endtask

  task automatic portBWrite(logic mbx, logic [W-1:0] data);
    @(negedge clkB);
    bCsN = 0; bEn = 1; bWrite = 1; bMbx = mbx; bDin = data;
    if (mbx && mail2Vacant) exp2Q.push_back(data);
    #1 check("R8 port B advance", {35'b0, bFifoAdv}, {35'b0, !mbx});
    @(negedge clkB);
    bCsN = 1; bEn = 0; bWrite = 0; bMbx = 0;
  endtask

  task automatic portBRead(logic mbx, string tag);
    @(negedge clkB);
    tagB = tag;
    bCsN = 0; bEn = 1; bWrite = 0; bMbx = mbx;
    #1 check("R4 port B drive", {35'b0, bDrive}, 36'd1);
    check("R8 port B advance", {35'b0, bFifoAdv}, {35'b0, !mbx});
    @(negedge clkB);
    bCsN = 1; bEn = 0; bMbx = 0;
  endtask

  task automatic portARead(logic mbx, string tag);
    @(negedge clkA);
    tagA = tag;
    aCsN = 0; aEn = 1; aWrite = 0; aMbx = mbx;
    #1 check("R4 port A drive", {35'b0, aDrive}, 36'd1);
    check("R8 port A advance", {35'b0, aFifoAdv}, {35'b0, !mbx});
    @(negedge clkA);
    aCsN = 1; aEn = 0; aMbx = 0;
  endtask

  task automatic waitVacant1(string tag);
    int n = 0;
    while (!mail1Vacant && n < 12) begin @(negedge clkA); n++; end
    check(tag, {35'b0, mail1Vacant && n <= 8}, 36'd1);
  endtask

  task automatic waitVacant2(string tag);
    int n = 0;
    while (!mail2Vacant && n < 12) begin @(negedge clkB); n++; end
    check(tag, {35'b0, mail2Vacant && n <= 8}, 36'd1);
  endtask

  // Full round trip A -> B
  task automatic trip1(logic [W-1:0] data);
    portAWrite(1, data);
    check("R2 mail1 flag low after write", {35'b0, mail1Vacant}, 36'd0);
    repeat (4) @(negedge clkB);
    portBRead(1, "R4 mail1 word at port B");
    waitVacant1("R6 mail1 flag returns");
  endtask

  task automatic trip2(logic [W-1:0] data);
    portBWrite(1, data);
    check("R3 mail2 flag low after write", {35'b0, mail2Vacant}, 36'd0);
    repeat (4) @(negedge clkA);
    portARead(1, "R4 mail2 word at port A");
    waitVacant2("R6 mail2 flag returns");
  endtask

  initial begin
    exp1Q.push_back('0);
    exp2Q.push_back('0);
    repeat (3) @(negedge clkA);
    check("R1 mail1 vacant at reset", {35'b0, mail1Vacant}, 36'd1);
    check("R1 mail2 vacant at reset", {35'b0, mail2Vacant}, 36'd1);
    rstN = 1;
    repeat (2) @(negedge clkA);
    check("R1 mail1 vacant after reset", {35'b0, mail1Vacant}, 36'd1);
    check("R1 mail2 vacant after reset", {35'b0, mail2Vacant}, 36'd1);
    check("R1 no drive while idle", {35'b0, aDrive}, 36'd0);

    portBRead(0, "R4 port B FIFO path");
    portARead(0, "R4 port A FIFO path");
    portBRead(1, "R1 mail1 zero after reset");
    portARead(1, "R1 mail2 zero after reset");
    portAWrite(0, 36'h1_2345_6789);
    portBWrite(0, 36'h9_8765_4321);
    check("R8 FIFO write leaves mail1 vacant", {35'b0, mail1Vacant}, 36'd1);

    // R9: stale read above must not free the flag after a write
    portAWrite(1, 36'h0_DEAD_BEEF);
    portBRead(1, "R9 early read sees new word");
    repeat (12) @(negedge clkA);
    check("R9 mail1 stays full after early read", {35'b0, mail1Vacant}, 36'd0);
    repeat (2) @(negedge clkB);
    portBRead(1, "R5 repeated read");
    waitVacant1("R6 mail1 freed by real read");
    portBRead(1, "R5 word kept after read");

    // Data patterns through both mailboxes
    trip1('0);
    trip1('1);
    trip1(36'hA_AAAA_AAAA);
    trip1(36'h5_5555_5555);
    trip2(36'hF_0F0F_0F0F);
    trip2(36'h0_1234_ABCD);
    trip2('1);

    // R7: write to a full mailbox is dropped
    portAWrite(1, 36'h7_7777_0001);
    portAWrite(1, 36'h6_6666_0002);
    check("R7 mail1 still full", {35'b0, mail1Vacant}, 36'd0);
    repeat (4) @(negedge clkB);
    portBRead(1, "R7 first word kept");
    waitVacant1("R6 mail1 after R7");
    portBWrite(1, 36'h8_0000_0003);
    portBWrite(1, 36'h9_0000_0004);
    repeat (4) @(negedge clkA);
    portARead(1, "R7 mail2 first word kept");
    waitVacant2("R6 mail2 after R7");

    // Both directions in the same window
    fork
      portAWrite(1, 36'h1_1111_1111);
      portBWrite(1, 36'h2_2222_2222);
    join
    check("R2 mail1 full in overlap", {35'b0, mail1Vacant}, 36'd0);
    check("R3 mail2 full in overlap", {35'b0, mail2Vacant}, 36'd0);
    repeat (4) @(negedge clkB);
    fork
      portBRead(1, "R4 overlap mail1");
      portARead(1, "R4 overlap mail2");
    join
    waitVacant1("R6 overlap mail1");
    waitVacant2("R6 overlap mail2");

    done = 1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clkA);
    if (!done) begin
      nErrors++;
      nChecks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end
endmodule